// File: doc/BRIEF.md
# Fractional-Order Difference Operator (Windowed Grünwald-Letnikov)

This block turns a stream of signed fixed-point samples into a running approximation of a fractional derivative (or, for a negative order, a fractional integral). The approximation is a weighted sum over the most recent `TAPS` accepted samples. The weights follow a binomial recurrence for the order alpha, which is fixed when the block is built. The step-size scaling factor is left to the surrounding datapath.

Internally the sum is laid out in transposed form. Each tap owns one multiplier and one register holding a partial sum. On every accepted sample, each tap adds its own product to the partial sum of the tap behind it. The last tap starts from zero, and the front tap's register is the result. There is no memory macro, and a sample's result appears one clock after the sample is offered. A valid strobe decides which cycles carry a sample. Idle cycles leave the whole history untouched, so the block can run under a slower or irregular sample rate.

Top module: `gl_frac_op`

## Requirements
- R1: The weights are integers W_j in units of 2^-16. W_0 = 65536. For j >= 1, W_j = (W_{j-1} * (j*65536 - A - 65536)) / (j*65536), computed with integer division that truncates toward zero, where A = `ORDER_Q16` is alpha scaled by 65536 (default 45875, about 0.7).
- R2: `in_sample` is two's complement with 8 integer bits and 24 fraction bits. Each weight is 22-bit two's complement with 16 fraction bits. `out_result` is 54-bit two's complement with 40 fraction bits. Products are formed at full precision.
- R3: Let x_0 be the newest accepted sample, x_1 the one before it, and so on. The result for x_0 is the sum over j = 0..TAPS-1 of W_j * x_j, taken modulo 2^54. Any sample not accepted since the last reset counts as zero.
- R4: A sample is accepted at a rising clock edge where `in_valid` is 1. Its result and `out_valid` = 1 appear on the outputs right after that same edge, one clock after the sample was presented.
- R5: At an edge where `in_valid` is 0, no stored partial sum changes, `out_result` holds its value and `out_valid` goes to 0.
- R6: While `rst_n` is low, and after it is released, the history is empty: `out_valid` is 0, `out_result` is 0, and samples offered during reset are ignored. Reset is applied asynchronously and released in step with the clock, through two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| in_valid | input | 1 | Sample strobe; 1 accepts `in_sample` at this edge |
| in_sample | input | 32 | Signed Q8.24 input sample |
| out_valid | output | 1 | 1 when `out_result` belongs to the sample accepted at the last edge |
| out_result | output | 54 | Signed Q14.40 windowed weighted sum |

## Verification
The weighted sum is driven with a table that mixes a rising ramp, negative and full-scale samples, and idle gaps. The ramp exposes a weight applied to the wrong delay. The gaps separate history that advances on every clock from history that advances only on accepted samples. A unit impulse followed by more than `TAPS` zeros walks the weight set out of the front of the chain one entry per sample, so each weight is checked on its own, and then shows the window emptying to zero. A run of full-scale negative samples fills the whole window to probe sign handling at the widest sums. A reset in the middle of a stream, with samples still offered during it, shows that no old partial sum leaks into the next result.

// File: rtl/gl_pkg.sv
package gl_pkg;

  localparam int GL_SMP_W  = 32;
  localparam int GL_COEF_W = 22;
  localparam int GL_ONE_Q16 = 65536;

  // Binomial weight j for order alpha (alpha scaled by 2^16), truncating division.
  function automatic longint gl_weight(input int j, input int alpha_q16);
    longint w;
    longint den;
    w = longint'(GL_ONE_Q16);
    for (int k = 1; k <= j; k++) begin
      den = longint'(k) * longint'(GL_ONE_Q16);
      w   = (w * (den - longint'(alpha_q16) - longint'(GL_ONE_Q16))) / den;
    end
    return w;
  endfunction

endpackage

// File: rtl/gl_rst_sync.sv
module gl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gl_coef_bank.sv
module gl_coef_bank #(
  parameter int TAPS      = 30,
  parameter int ORDER_Q16 = 45875,
  parameter int COEF_W    = gl_pkg::GL_COEF_W
) (
  output logic signed [COEF_W-1:0] coef_o [TAPS]
);

  for (genvar g = 0; g < TAPS; g++) begin : g_coef
    localparam longint WRAW = gl_pkg::gl_weight(g, ORDER_Q16);
    localparam logic signed [COEF_W-1:0] WVAL = COEF_W'(WRAW);
    assign coef_o[g] = WVAL;
  end

endmodule

// File: rtl/gl_tap_cell.sv
module gl_tap_cell #(
  parameter int SMP_W  = gl_pkg::GL_SMP_W,
  parameter int COEF_W = gl_pkg::GL_COEF_W,
  parameter int RES_W  = SMP_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [SMP_W-1:0]  sample_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [RES_W-1:0]  carry_i,
  output logic signed [RES_W-1:0]  sum_o
);

  logic signed [RES_W-1:0] smp_ext;
  logic signed [RES_W-1:0] coef_ext;
  logic signed [RES_W-1:0] prod;
  logic signed [RES_W-1:0] sum_d;
  logic signed [RES_W-1:0] sum_q;

  // Next-state: full-precision product plus the partial sum of the tap behind.
  always_comb begin
    smp_ext  = RES_W'(sample_i);
    coef_ext = RES_W'(coef_i);
    prod     = smp_ext * coef_ext;
    sum_d    = sum_q;
    if (en) sum_d = prod + carry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  // R5: an idle edge leaves the stored partial sum untouched
  a_r5_tap_stable: assert property (@(posedge clk) disable iff (rst_n !== 1'b1)
    !en |=> $stable(sum_q));

  // R6: the first edge after reset release sees an empty partial sum
  a_r6_clear_on_release: assert property (@(posedge clk)
    $rose(rst_n) |-> (sum_q == '0));

endmodule

// File: rtl/gl_frac_op.sv
module gl_frac_op #(
  parameter int TAPS      = 30,
  parameter int ORDER_Q16 = 45875,
  parameter int SMP_W     = gl_pkg::GL_SMP_W,
  parameter int COEF_W    = gl_pkg::GL_COEF_W,
  parameter int RES_W     = SMP_W + COEF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  output logic                    out_valid,
  output logic signed [RES_W-1:0] out_result
);

  localparam int LAST = TAPS - 1;

  logic                     rst_s;
  logic signed [COEF_W-1:0] coef [TAPS];
  logic signed [RES_W-1:0]  psum [TAPS];
  logic signed [RES_W-1:0]  carry [TAPS];
  logic                     vld_d;
  logic                     vld_q;

  gl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  gl_coef_bank #(
    .TAPS      (TAPS),
    .ORDER_Q16 (ORDER_Q16),
    .COEF_W    (COEF_W)
  ) u_coef (
    .coef_o (coef)
  );

  // Transposed chain: tap i adds onto tap i+1, the last tap starts from zero,
  // and tap 0's register is the result.
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g == LAST) begin : g_end
      assign carry[g] = '0;
    end else begin : g_mid
      assign carry[g] = psum[g+1];
    end

    gl_tap_cell #(
      .SMP_W  (SMP_W),
      .COEF_W (COEF_W),
      .RES_W  (RES_W)
    ) u_tap (
      .clk      (clk),
      .rst_n    (rst_s),
      .en       (in_valid),
      .sample_i (in_sample),
      .coef_i   (coef[g]),
      .carry_i  (carry[g]),
      .sum_o    (psum[g])
    );
  end

  always_comb begin
    vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid  = vld_q;
  assign out_result = psum[0];

  // R4: an accepted sample yields a valid result right after the edge
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst_s !== 1'b1)
    in_valid |=> out_valid);

  // R5: an idle edge drops out_valid and holds the result
  a_r5_hold_result: assert property (@(posedge clk) disable iff (rst_s !== 1'b1)
    !in_valid |=> (!out_valid && $stable(out_result)));

  // R6: while the synchronized reset is low the outputs stay cleared
  a_r6_outputs_clear: assert property (@(posedge clk)
    (rst_s === 1'b0) |-> (!out_valid && out_result == '0));

endmodule

// File: tb/sim_gl_frac_op.sv
module sim_gl_frac_op;

  localparam int TAPS  = 30;
  localparam int ORDQ  = 45875;
  localparam int SMP_W = 32;
  localparam int RES_W = 54;
  localparam int NVEC  = 20;

  // {valid, sample}; samples in Q8.24
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 32'h0100_0000}, {1'b1, 32'h0200_0000}, {1'b1, 32'h0300_0000},
    {1'b1, 32'h0400_0000}, {1'b0, 32'hDEAD_BEEF}, {1'b1, 32'h0500_0000},
    {1'b1, 32'hFF80_0000}, {1'b0, 32'h1234_5678}, {1'b0, 32'h7FFF_FFFF},
    {1'b1, 32'h7FFF_FFFF}, {1'b1, 32'h8000_0000}, {1'b1, 32'h0000_0001},
    {1'b1, 32'hFFFF_FFFF}, {1'b1, 32'h0040_0000}, {1'b0, 32'h0000_0000},
    {1'b1, 32'h0600_0000}, {1'b1, 32'h0700_0000}, {1'b1, 32'hF000_0000},
    {1'b1, 32'h0123_4567}, {1'b1, 32'h0800_0000}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic signed [SMP_W-1:0] in_sample = '0;
  logic                    out_valid;
  logic signed [RES_W-1:0] out_result;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  longint wt [TAPS];
  longint hist [TAPS];
  logic signed [RES_W-1:0] last_out;

  always #5 clk = ~clk;

  gl_frac_op #(.TAPS(TAPS), .ORDER_Q16(ORDQ)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // R1 recurrence, written from the requirement
  function automatic longint ref_w(input int j);
    longint w = 65536;
    for (int k = 1; k <= j; k++)
      w = (w * (longint'(k) * 65536 - ORDQ - 65536)) / (longint'(k) * 65536);
    return w;
  endfunction

  function automatic logic signed [RES_W-1:0] model_sum();
    longint s = 0;
    for (int j = 0; j < TAPS; j++) s += wt[j] * hist[j];
    return RES_W'(s);
  endfunction

  task automatic clear_model();
    for (int j = 0; j < TAPS; j++) hist[j] = 0;
    last_out = '0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] x, input string req);
    logic signed [RES_W-1:0] expv;
    @(negedge clk);
    in_valid  = v;
    in_sample = x;
    if (v) begin
      for (int j = TAPS - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = longint'($signed(x));
      last_out = model_sum();
    end
    expv = last_out;
    @(posedge clk);
    #2;
    check(out_valid == v, "R4", "out_valid", longint'(out_valid), longint'(v));
    check(out_result == expv, req, "out_result", longint'(out_result), longint'(expv));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    in_valid  = 1'b1;
    in_sample = 32'h0500_0000;
    repeat (3) @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    clear_model();
    check(out_valid == 1'b0, "R6", "out_valid after reset", longint'(out_valid), 0);
    check(out_result == '0, "R6", "out_result after reset", longint'(out_result), 0);
  endtask

  initial begin
    for (int j = 0; j < TAPS; j++) wt[j] = ref_w(j);
    clear_model();
    repeat (2) @(posedge clk);
    #2;
    check(out_valid == 1'b0, "R6", "out_valid in reset", longint'(out_valid), 0);
    check(out_result == '0, "R6", "out_result in reset", longint'(out_result), 0);
    do_reset();

    // R3/R5: table of ramp, mixed-sign and gapped samples
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][32], VEC[i][31:0], VEC[i][32] ? "R3" : "R5");

    // R6: reset mid-stream, with samples offered during reset
    do_reset();

    // R1/R2: unit impulse walks each weight out of the front, then drains
    step(1'b1, 32'h0100_0000, "R1");
    check(out_result == RES_W'(longint'(1) <<< 40), "R2", "w0 at Q14.40",
          longint'(out_result), longint'(1) <<< 40);
    for (int k = 1; k < TAPS + 3; k++) step(1'b1, 32'h0000_0000, "R1");
    check(out_result == '0, "R3", "window drained", longint'(out_result), 0);

    // R5: idle edges after a value
    step(1'b1, 32'h0280_0000, "R3");
    step(1'b0, 32'h7FFF_0000, "R5");
    step(1'b0, 32'h8000_0000, "R5");
    step(1'b1, 32'h0000_0000, "R5");

    // R2/R3: full window of full-scale negative samples
    for (int k = 0; k < TAPS + 2; k++) step(1'b1, 32'h8000_0000, "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule